// File: doc/BRIEF.md
# Character Panel Write Controller

This block sits between a simple byte-wide host port and the parallel bus of a character or graphics display controller. After reset it waits, fully locked, until the host raises its enable line for the first time. It then plays a fixed power-up sequence of words held in a small on-chip ROM to the panel, one bus transfer per word. Once that sequence has ended, the block raises a done flag and hands the port over to the host. Each host byte is then sent as a command or as a character code, as chosen by a select line.

Every panel transfer follows the same phases: select the panel, drive register select and data, wait a setup count, pulse the strobe for a width count, then hold everything for a count before deselecting. A ready output tells the host when a new byte will be taken. Panel reads are never issued.

State machine. States: `ST_LOCKED` (after reset, waiting for the first enable), `ST_FETCH` (look at the next ROM word), `ST_SETUP`, `ST_STROBE`, `ST_HOLD` (the three bus phases), and `ST_IDLE` (the host owns the port). Transitions:
- LOCKED to FETCH on enable high.
- FETCH to SETUP for a word to send.
- FETCH to IDLE at the end mark or at the word limit, with done set.
- SETUP to STROBE, STROBE to HOLD and HOLD onward, each when its count expires.
- HOLD to FETCH while init is running, or to IDLE after init.
- IDLE to SETUP on an accepted host write.
- Any state to LOCKED on reset.

Top module: `chr_panel_ctrl`

## Requirements
- R1: After a synchronous reset the block is locked. Chip select is high (deselected), the strobe is low, and ready and done are low.
- R2: Before the first enable, host writes have no effect: no panel transfer takes place and done stays low.
- R3: On the first enable, the block sends the ROM words in address order, one transfer per word. Each word is 10 bits: bits 7:0 go on the data bus; bit 9 set means instruction and drives register select low; bit 9 clear means data and drives register select high. The default ROM holds instructions 0x38, 0x0C, 0x01 and 0x06, then data 0x2A, then an end mark.
- R4: The sequence ends at a word with bit 8 set (that word is not sent) or after MAX_INIT_WORDS words, whichever comes first. Done then rises and stays high until reset.
- R5: Ready is high only when the sequence has finished, no transfer is in progress and enable is high.
- R6: An accepted host write with the select line low is sent as a command: register select low, data bus equal to the host byte.
- R7: An accepted host write with the select line high is sent as character data: register select high, data bus equal to the host byte.
- R8: In every transfer, chip select is low for SETUP_CYC cycles with the strobe low, then PULSE_CYC cycles with the strobe high, then HOLD_CYC cycles with the strobe low. Data and register select stay constant while chip select is low.
- R9: The read/write line is low at all times.
- R10: A host write presented while ready is low is dropped. This covers a write during a transfer and a write while enable is low.
- R11: A reset after the sequence has finished re-arms the block, so the next enable replays the whole ROM sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_en | input | 1 | Host enable; low locks the port |
| host_wr | input | 1 | Host write request, taken when ready is high |
| host_dc | input | 1 | 1 = character data, 0 = command |
| host_byte | input | 8 | Host byte |
| host_ready | output | 1 | Port free for a host write |
| init_done | output | 1 | Power-up sequence finished (sticky) |
| pnl_db | output | 8 | Panel data bus |
| pnl_csn | output | 1 | Panel chip select, active low |
| pnl_rs | output | 1 | Register select: 0 instruction, 1 data |
| pnl_rw | output | 1 | Read/write, held low (write) |
| pnl_strobe | output | 1 | Panel enable strobe, active high |

## Verification
The hardest situation to reach from the ports is the word-count limit ending the sequence before the ROM's end mark. With the default ROM contents, only the end mark ever fires. The bench therefore runs a second instance with a word limit of three beside the main one, and checks that it finishes after exactly three transfers. A second hard situation is a write arriving in the cycles just after acceptance. The bench holds the write request high with a new byte through the setup phase, and confirms that only the first byte reaches the panel.

// File: rtl/chr_panel_pkg.sv
package chr_panel_pkg;

    typedef enum logic [2:0] {
        ST_LOCKED,
        ST_FETCH,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_IDLE
    } seq_state_e;

    // ROM word layout: bit 9 instruction flag, bit 8 end mark, bits 7:0 value
    typedef struct packed {
        logic       is_instr;
        logic       is_end;
        logic [7:0] value;
    } init_word_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/chr_panel_init_rom.sv
module chr_panel_init_rom
    import chr_panel_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output init_word_t        word
);

    function automatic init_word_t entry(input int idx);
        init_word_t w;
        w = '{is_instr: 1'b1, is_end: 1'b1, value: 8'h00};
        case (idx)
            0: w = '{is_instr: 1'b1, is_end: 1'b0, value: 8'h38};
            1: w = '{is_instr: 1'b1, is_end: 1'b0, value: 8'h0C};
            2: w = '{is_instr: 1'b1, is_end: 1'b0, value: 8'h01};
            3: w = '{is_instr: 1'b1, is_end: 1'b0, value: 8'h06};
            4: w = '{is_instr: 1'b0, is_end: 1'b0, value: 8'h2A};
            default: w = '{is_instr: 1'b1, is_end: 1'b1, value: 8'h00};
        endcase
        return w;
    endfunction

    always_comb begin
        word = entry(int'(addr));
    end

endmodule

// File: rtl/chr_panel_timer.sv
module chr_panel_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/chr_panel_seq.sv
module chr_panel_seq
    import chr_panel_pkg::*;
#(
    parameter int SETUP_CYC      = 2,
    parameter int PULSE_CYC      = 3,
    parameter int HOLD_CYC       = 2,
    parameter int MAX_INIT_WORDS = 8,
    parameter int PTR_W          = 4,
    parameter int CNT_W          = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_en,
    input  logic             host_wr,
    input  logic             host_dc,
    input  logic [7:0]       host_byte,
    output logic [PTR_W-1:0] rom_addr,
    input  init_word_t       rom_word,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    input  logic             tmr_expired,
    output logic             host_ready,
    output logic             init_done,
    output logic [7:0]       pnl_db,
    output logic             pnl_csn,
    output logic             pnl_rs,
    output logic             pnl_rw,
    output logic             pnl_strobe
);

    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [PTR_W-1:0] PTR_LIM  = PTR_W'(MAX_INIT_WORDS);

    seq_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q;
    logic             done_q;
    logic [7:0]       db_q;
    logic             rs_q;
    logic             seq_end;
    logic             accept;

    assign rom_addr = ptr_q;
    assign seq_end  = rom_word.is_end || (ptr_q == PTR_LIM);
    assign accept   = (state_q == ST_IDLE) && host_en && host_wr;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and phase timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_LOCKED: begin
                if (host_en) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (seq_end) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    state_d = done_q ? ST_IDLE : ST_FETCH;
                end
            end
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                end
            end
            default: begin
                state_d = ST_LOCKED;
            end
        endcase
    end

    // Sequence pointer, done flag and latched bus values
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            done_q <= 1'b0;
            db_q   <= '0;
            rs_q   <= 1'b0;
        end else begin
            if (state_q == ST_FETCH) begin
                if (seq_end) begin
                    done_q <= 1'b1;
                end else begin
                    db_q  <= rom_word.value;
                    rs_q  <= ~rom_word.is_instr;
                    ptr_q <= ptr_q + 1'b1;
                end
            end
            if (accept) begin
                db_q <= host_byte;
                rs_q <= host_dc;
            end
        end
    end

    // Outputs
    always_comb begin
        pnl_csn    = 1'b1;
        pnl_strobe = 1'b0;
        host_ready = 1'b0;
        unique case (state_q)
            ST_SETUP:  pnl_csn = 1'b0;
            ST_STROBE: begin
                pnl_csn    = 1'b0;
                pnl_strobe = 1'b1;
            end
            ST_HOLD:   pnl_csn = 1'b0;
            ST_IDLE:   host_ready = host_en;
            default:   pnl_csn = 1'b1;
        endcase
        pnl_db    = db_q;
        pnl_rs    = rs_q;
        pnl_rw    = 1'b0;
        init_done = done_q;
    end

endmodule

// File: rtl/chr_panel_ctrl.sv
module chr_panel_ctrl
    import chr_panel_pkg::*;
#(
    parameter int SETUP_CYC      = 2,
    parameter int PULSE_CYC      = 3,
    parameter int HOLD_CYC       = 2,
    parameter int MAX_INIT_WORDS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_en,
    input  logic       host_wr,
    input  logic       host_dc,
    input  logic [7:0] host_byte,
    output logic       host_ready,
    output logic       init_done,
    output logic [7:0] pnl_db,
    output logic       pnl_csn,
    output logic       pnl_rs,
    output logic       pnl_rw,
    output logic       pnl_strobe
);

    localparam int PTR_W = $clog2(MAX_INIT_WORDS + 1);
    localparam int CNT_W = (max3(SETUP_CYC, PULSE_CYC, HOLD_CYC) > 1)
                         ? $clog2(max3(SETUP_CYC, PULSE_CYC, HOLD_CYC)) : 1;

    logic [PTR_W-1:0] rom_addr;
    init_word_t       rom_word;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    chr_panel_init_rom #(
        .ADDR_W (PTR_W)
    ) u_rom (
        .addr (rom_addr),
        .word (rom_word)
    );

    chr_panel_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    chr_panel_seq #(
        .SETUP_CYC      (SETUP_CYC),
        .PULSE_CYC      (PULSE_CYC),
        .HOLD_CYC       (HOLD_CYC),
        .MAX_INIT_WORDS (MAX_INIT_WORDS),
        .PTR_W          (PTR_W),
        .CNT_W          (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .host_en     (host_en),
        .host_wr     (host_wr),
        .host_dc     (host_dc),
        .host_byte   (host_byte),
        .rom_addr    (rom_addr),
        .rom_word    (rom_word),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_expired (tmr_expired),
        .host_ready  (host_ready),
        .init_done   (init_done),
        .pnl_db      (pnl_db),
        .pnl_csn     (pnl_csn),
        .pnl_rs      (pnl_rs),
        .pnl_rw      (pnl_rw),
        .pnl_strobe  (pnl_strobe)
    );

endmodule

// File: rtl/chr_panel_ctrl_chk.sv
module chr_panel_ctrl_chk #(
    parameter int PULSE_CYC = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       host_en,
    input logic       host_ready,
    input logic       init_done,
    input logic [7:0] pnl_db,
    input logic       pnl_csn,
    input logic       pnl_rs,
    input logic       pnl_strobe
);

    int hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= 0;
        end else if (pnl_strobe) begin
            hi_run <= hi_run + 1;
        end else begin
            hi_run <= 0;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pnl_csn && !pnl_strobe && !init_done && !host_ready));

    a_r4_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r5_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (init_done && pnl_csn && host_en));

    a_r8_strobe_inside_select: assert property (@(posedge clk) disable iff (rst)
        pnl_strobe |-> !pnl_csn);

    a_r8_bus_stable: assert property (@(posedge clk) disable iff (rst)
        (!pnl_csn && !$past(pnl_csn)) |-> ($stable(pnl_db) && $stable(pnl_rs)));

    a_r8_setup_before_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(pnl_strobe) |-> !$past(pnl_csn));

    a_r8_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $fell(pnl_strobe) |-> (hi_run == PULSE_CYC));

endmodule

bind chr_panel_ctrl chr_panel_ctrl_chk #(
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_en    (host_en),
    .host_ready (host_ready),
    .init_done  (init_done),
    .pnl_db     (pnl_db),
    .pnl_csn    (pnl_csn),
    .pnl_rs     (pnl_rs),
    .pnl_strobe (pnl_strobe)
);

// File: tb/test_chr_panel_ctrl.sv
`timescale 1ns/1ps
module test_chr_panel_ctrl;

    localparam int SU = 2;
    localparam int PW = 3;
    localparam int HO = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_en = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_dc = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       host_ready, init_done, pnl_csn, pnl_rs, pnl_rw, pnl_strobe;
    logic [7:0] pnl_db;
    logic       s_ready, s_done, s_csn, s_rs, s_rw, s_strobe;
    logic [7:0] s_db;

    always #2.5 clk = ~clk;

    chr_panel_ctrl #(.SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HO), .MAX_INIT_WORDS(8)) i_chr_panel_ctrl (
        .clk(clk), .rst(rst), .host_en(host_en), .host_wr(host_wr), .host_dc(host_dc),
        .host_byte(host_byte), .host_ready(host_ready), .init_done(init_done),
        .pnl_db(pnl_db), .pnl_csn(pnl_csn), .pnl_rs(pnl_rs), .pnl_rw(pnl_rw), .pnl_strobe(pnl_strobe));

    chr_panel_ctrl #(.SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HO), .MAX_INIT_WORDS(3)) i_chr_panel_ctrl_short (
        .clk(clk), .rst(rst), .host_en(host_en), .host_wr(host_wr), .host_dc(host_dc),
        .host_byte(host_byte), .host_ready(s_ready), .init_done(s_done),
        .pnl_db(s_db), .pnl_csn(s_csn), .pnl_rs(s_rs), .pnl_rw(s_rw), .pnl_strobe(s_strobe));

    // Stimulus table: {expected rs, host_dc, host_byte}
    localparam logic [9:0] VEC [6] = '{
        {1'b1, 1'b1, 8'h48}, {1'b1, 1'b1, 8'h69}, {1'b0, 1'b0, 8'h80},
        {1'b1, 1'b1, 8'h00}, {1'b0, 1'b0, 8'hFF}, {1'b1, 1'b1, 8'h7E}};

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Panel model: logs each transfer and its phase lengths
    int   n_xfer = 0;
    logic log_rs [64];
    logic [7:0] log_db [64];
    int   log_su [64], log_pw [64], log_ho [64];
    bit   in_xfer = 1'b0;
    int   su = 0, pw = 0, ho = 0;
    logic [7:0] first_db;
    logic first_rs;
    int   unstable = 0, rw_bad = 0, rdy_bad = 0, s_cnt = 0;
    logic prev_s = 1'b0;

    always @(negedge clk) begin
        if (pnl_rw || s_rw) rw_bad++;
        if (host_ready && !(pnl_csn && init_done)) rdy_bad++;
        if (!pnl_csn) begin
            if (!in_xfer) begin
                in_xfer = 1'b1; su = 0; pw = 0; ho = 0;
                first_db = pnl_db; first_rs = pnl_rs;
            end
            if (pnl_db != first_db || pnl_rs != first_rs) unstable++;
            if (pnl_strobe) pw++;
            else if (pw == 0) su++;
            else ho++;
        end else if (in_xfer) begin
            if (n_xfer < 64) begin
                log_rs[n_xfer] = first_rs; log_db[n_xfer] = first_db;
                log_su[n_xfer] = su; log_pw[n_xfer] = pw; log_ho[n_xfer] = ho;
            end
            n_xfer++;
            in_xfer = 1'b0;
        end
        if (prev_s && !s_strobe) s_cnt++;
        prev_s = s_strobe;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ready();
        int t = 0;
        while (!host_ready && t < 2000) begin
            tick();
            t++;
        end
    endtask

    task automatic host_write(input logic dc, input logic [7:0] b);
        wait_ready();
        host_dc = dc; host_byte = b; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic chk_xfer(input int idx, input logic rs, input logic [7:0] db, input string req);
        chk(req, "rs", int'(log_rs[idx]), int'(rs));
        chk(req, "db", int'(log_db[idx]), int'(db));
        chk("R8", "setup cycles", log_su[idx], SU);
        chk("R8", "pulse cycles", log_pw[idx], PW);
        chk("R8", "hold cycles", log_ho[idx], HO);
    endtask

    task automatic run_init_and_check(input int base);
        int t = 0;
        while (!init_done && t < 2000) begin
            tick();
            t++;
        end
        chk("R4", "done after sequence", int'(init_done), 1);
        chk("R3", "init transfer count", n_xfer - base, 5);
        chk_xfer(base + 0, 1'b0, 8'h38, "R3");
        chk_xfer(base + 1, 1'b0, 8'h0C, "R3");
        chk_xfer(base + 2, 1'b0, 8'h01, "R3");
        chk_xfer(base + 3, 1'b0, 8'h06, "R3");
        chk_xfer(base + 4, 1'b1, 8'h2A, "R3");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        chk("R1", "csn", int'(pnl_csn), 1);
        chk("R1", "strobe", int'(pnl_strobe), 0);
        chk("R1", "ready", int'(host_ready), 0);
        chk("R1", "done", int'(init_done), 0);
        chk("R9", "rw", int'(pnl_rw), 0);

        // R2: writes before the first enable do nothing
        for (int i = 0; i < 4; i++) begin
            host_wr = 1'b1; host_dc = i[0]; host_byte = 8'(8'h30 + i);
            tick();
            host_wr = 1'b0;
            repeat (3) tick();
        end
        repeat (10) tick();
        chk("R2", "transfers while locked", n_xfer, 0);
        chk("R2", "done while locked", int'(init_done), 0);
        chk("R5", "ready while locked", int'(host_ready), 0);

        // R3/R4: first enable plays the ROM
        host_en = 1'b1;
        run_init_and_check(0);
        chk("R4", "short instance done", int'(s_done), 1);
        chk("R4", "short instance word limit", s_cnt, 3);
        repeat (20) tick();
        chk("R4", "done stays high", int'(init_done), 1);
        chk("R4", "no extra transfers", n_xfer, 5);

        // R6/R7: table of host writes
        foreach (VEC[i]) begin
            base = n_xfer;
            host_write(VEC[i][8], VEC[i][7:0]);
            wait_ready();
            chk(VEC[i][9] ? "R7" : "R6", "one transfer", n_xfer - base, 1);
            chk_xfer(base, VEC[i][9], VEC[i][7:0], VEC[i][9] ? "R7" : "R6");
        end

        // R10: write held through a busy transfer is dropped
        base = n_xfer;
        wait_ready();
        host_dc = 1'b1; host_byte = 8'h41; host_wr = 1'b1;
        tick();
        host_byte = 8'h55; host_dc = 1'b0;
        chk("R5", "ready low during transfer", int'(host_ready), 0);
        repeat (3) tick();
        host_wr = 1'b0;
        wait_ready();
        repeat (3) tick();
        chk("R10", "writes while busy", n_xfer - base, 1);
        chk_xfer(base, 1'b1, 8'h41, "R10");

        // R10: enable low in idle blocks writes
        base = n_xfer;
        host_en = 1'b0;
        tick();
        chk("R5", "ready with enable low", int'(host_ready), 0);
        host_wr = 1'b1; host_byte = 8'h99; host_dc = 1'b0;
        repeat (3) tick();
        host_wr = 1'b0;
        repeat (10) tick();
        chk("R10", "writes while disabled", n_xfer - base, 0);
        host_en = 1'b1;
        tick();
        chk("R5", "ready back with enable", int'(host_ready), 1);

        // R11: reset re-arms the power-up sequence
        base = n_xfer;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R11", "done cleared", int'(init_done), 0);
        chk("R11", "ready cleared", int'(host_ready), 0);
        run_init_and_check(base);
        chk("R11", "replay count", n_xfer - base, 5);

        // R8/R9: global observations
        chk("R8", "bus changes while selected", unstable, 0);
        chk("R9", "rw seen high", rw_bad, 0);
        chk("R5", "ready while busy or before done", rdy_bad, 0);

        finish_run();
    end

endmodule